// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a small byte-addressed serial memory that answers as a slave on a two-wire bus (SCL clock, SDA data). A fast system clock samples both lines through short synchronisers and finds start and stop conditions and SCL edges. A state machine then receives the device byte, two word-address bytes and any data bytes, most significant bit first, and answers each byte with an acknowledge. It drives SDA only in open-drain fashion: `sda_oe_o` high pulls the line low, and low releases it.

A write puts the address bytes into an 11-bit address counter. The first address byte supplies the top bits in its low three bits, and the second byte supplies the low eight bits. Each data byte then goes into a synchronous 2048-byte array, and the counter steps after every byte. A read is a device byte with the direction bit set. It streams bytes from the counter for as long as the master acknowledges. When the master withholds the acknowledge, the slave goes quiet until a stop condition. A random read is made by writing only the address and then issuing a repeated start.

A stop that ends a write carrying at least one data byte starts a self-timed write cycle of `WR_CYCLES` system clocks. Until that cycle ends, the slave does not acknowledge its device byte, so a master can poll for completion.

States:
- `ST_IDLE` waits for a start.
- `ST_DEV` receives the device byte.
- `ST_DEV_ACK` answers the device byte.
- `ST_AHI` and `ST_AHI_ACK` take and answer the high address byte.
- `ST_ALO` and `ST_ALO_ACK` take and answer the low address byte.
- `ST_WDAT` and `ST_WDAT_ACK` take and answer each write data byte.
- `ST_RDAT` shifts out one read byte.
- `ST_RACK` samples the master's acknowledge.
- `ST_HOLD` stays passive after a refused read acknowledge.

Transitions:
- A stop condition leads from any state to `ST_IDLE`.
- A start condition leads from any state to `ST_DEV`.
- Other transitions happen on an SCL falling edge:
  - `ST_DEV` goes to `ST_DEV_ACK` on an address match while not busy, and to `ST_IDLE` otherwise.
  - `ST_DEV_ACK` goes to `ST_RDAT` or `ST_AHI`, according to the direction bit.
  - `ST_AHI` goes to `ST_AHI_ACK`, then to `ST_ALO`, then to `ST_ALO_ACK`, then to `ST_WDAT`.
  - `ST_WDAT` and `ST_WDAT_ACK` alternate.
  - `ST_RDAT` goes to `ST_RACK`.
  - `ST_RACK` goes back to `ST_RDAT` when the master acknowledges, and to `ST_HOLD` when it does not.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset and whenever the slave is idle, `sda_oe_o` is 0, so the data line is released.
- R2: A start condition in any state, including one in the middle of a byte, clears the bit count and restarts device-byte reception, so a repeated start is answered like a first start.
- R3: The device byte is acknowledged (SDA low on the ninth pulse) only when its upper seven bits equal `DEV_ADDR`. Otherwise SDA stays released for the rest of the transaction, until the next start.
- R4: In a write (device byte bit 0 = 0), the low three bits of the first address byte form address bits 10..8, and the second byte forms bits 7..0. Each data byte that follows is acknowledged and stored at the counter, MSB received first.
- R5: The address counter advances by one after every data byte written or read, and wraps from 2047 to 0.
- R6: A stop after a write that carried at least one complete data byte makes the slave busy for `WR_CYCLES` system clocks. While busy, it does not acknowledge its device byte. Once the cycle ends, it acknowledges again.
- R7: A stop after a write that carried no complete data byte (address setup only) does not start the write cycle.
- R8: In a read (device byte bit 0 = 1), after the acknowledge the slave sends the byte at the counter, MSB first. It changes `sda_oe_o` only while SCL is low.
- R9: After each read byte, the slave releases SDA and samples the ninth pulse. On SDA low it sends the next byte. On SDA high it keeps SDA released for any further pulses until a stop.
- R10: A stop condition in any state returns the slave to idle, ready for a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The case of interest is a start condition that lands while a write data byte is half shifted. At that moment, the byte shifter and the start detector both want to act in the same system cycle. The bench provokes it by breaking off after three data bits with a repeated start. It judges the outcome in three ways:
- the following device byte must be acknowledged;
- the completed bytes before the break must read back unchanged;
- the closing stop must still start the write cycle, which an immediate poll then sees as no acknowledge.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK,
        ST_HOLD
    } slv_state_e;

endpackage

// File: rtl/twi_bus_sync.sv
module twi_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] pin_in;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] lvl_d;

    assign pin_in = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] sh;
        logic                   prev;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh   <= '1;
                prev <= 1'b1;
            end else begin
                sh   <= {sh[SYNC_STAGES-2:0], pin_in[g]};
                prev <= sh[SYNC_STAGES-1];
            end
        end
        assign lvl[g]   = sh[SYNC_STAGES-1];
        assign lvl_d[g] = prev;
    end

    assign sda_lvl   = lvl[1];
    assign scl_rise  = lvl[0] & ~lvl_d[0];
    assign scl_fall  = ~lvl[0] & lvl_d[0];
    assign start_det = lvl[0] & lvl_d[0] & lvl_d[1] & ~lvl[1];
    assign stop_det  = lvl[0] & lvl_d[0] & ~lvl_d[1] & lvl[1];

endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH),
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        rdata <= cells[raddr];
    end

endmodule

// File: rtl/twi_wr_timer.sv
module twi_wr_timer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (kick) begin
            cnt_q <= CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_mem_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         MEM_BYTES   = 2048,
    parameter int         WR_CYCLES   = 5000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);
    localparam int AW      = $clog2(MEM_BYTES);
    localparam int HI_BITS = AW - 8;
    localparam int BITS    = 8;

    slv_state_e state_q, state_d;

    logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          busy, mem_we, byte_done, dev_match;
    logic [3:0]    bit_q;
    logic [7:0]    sr_q, tx_q, rdata;
    logic [AW-1:0] addr_q;
    logic          oe_q, mack_q, wrote_q;

    twi_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_mem_array #(.DEPTH(MEM_BYTES), .AW(AW), .DW(8)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (addr_q),
        .wdata (sr_q),
        .raddr (addr_q),
        .rdata (rdata)
    );

    twi_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .kick  (stop_det & wrote_q),
        .busy  (busy)
    );

    assign byte_done = (bit_q == 4'(BITS));
    assign dev_match = (sr_q[7:1] == DEV_ADDR);
    assign mem_we    = (state_q == ST_WDAT) && scl_fall && byte_done
                       && !start_det && !stop_det;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_DEV;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_DEV:      if (scl_fall && byte_done)
                                 state_d = (dev_match && !busy) ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:  if (scl_fall) state_d = sr_q[0] ? ST_RDAT : ST_AHI;
                ST_AHI:      if (scl_fall && byte_done) state_d = ST_AHI_ACK;
                ST_AHI_ACK:  if (scl_fall) state_d = ST_ALO;
                ST_ALO:      if (scl_fall && byte_done) state_d = ST_ALO_ACK;
                ST_ALO_ACK:  if (scl_fall) state_d = ST_WDAT;
                ST_WDAT:     if (scl_fall && byte_done) state_d = ST_WDAT_ACK;
                ST_WDAT_ACK: if (scl_fall) state_d = ST_WDAT;
                ST_RDAT:     if (scl_fall && byte_done) state_d = ST_RACK;
                ST_RACK:     if (scl_fall) state_d = mack_q ? ST_RDAT : ST_HOLD;
                ST_HOLD:     state_d = ST_HOLD;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q    <= 1'b0;
            bit_q   <= '0;
            sr_q    <= '0;
            tx_q    <= '0;
            addr_q  <= '0;
            mack_q  <= 1'b0;
            wrote_q <= 1'b0;
        end else if (stop_det) begin
            oe_q    <= 1'b0;
            bit_q   <= '0;
            wrote_q <= 1'b0;
        end else if (start_det) begin
            oe_q  <= 1'b0;
            bit_q <= '0;
        end else begin
            unique case (state_q)
                ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (scl_rise && !byte_done) begin
                        sr_q  <= {sr_q[6:0], sda_s};
                        bit_q <= bit_q + 4'd1;
                    end
                    if (scl_fall && byte_done) begin
                        bit_q <= '0;
                        oe_q  <= (state_q == ST_DEV) ? (dev_match && !busy) : 1'b1;
                        if (state_q == ST_WDAT) begin
                            addr_q  <= addr_q + AW'(1);
                            wrote_q <= 1'b1;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        bit_q <= '0;
                        if (sr_q[0]) begin
                            tx_q <= rdata;
                            oe_q <= ~rdata[7];
                        end else begin
                            oe_q <= 1'b0;
                        end
                    end
                end
                ST_AHI_ACK: begin
                    if (scl_fall) begin
                        oe_q             <= 1'b0;
                        addr_q[AW-1:8]   <= sr_q[HI_BITS-1:0];
                    end
                end
                ST_ALO_ACK: begin
                    if (scl_fall) begin
                        oe_q        <= 1'b0;
                        addr_q[7:0] <= sr_q;
                    end
                end
                ST_WDAT_ACK: begin
                    if (scl_fall) oe_q <= 1'b0;
                end
                ST_RDAT: begin
                    if (scl_rise && !byte_done) bit_q <= bit_q + 4'd1;
                    if (scl_fall) begin
                        if (byte_done) begin
                            oe_q   <= 1'b0;
                            bit_q  <= '0;
                            addr_q <= addr_q + AW'(1);
                        end else begin
                            oe_q <= ~tx_q[6];
                            tx_q <= {tx_q[6:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) mack_q <= ~sda_s;
                    if (scl_fall) begin
                        if (mack_q) begin
                            tx_q <= rdata;
                            oe_q <= ~rdata[7];
                        end else begin
                            oe_q <= 1'b0;
                        end
                    end
                end
                ST_IDLE, ST_HOLD: oe_q <= 1'b0;
                default:          oe_q <= 1'b0;
            endcase
        end
    end

    assign sda_oe_o = oe_q;

endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk
    import twi_mem_pkg::*;
#(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_oe_o,
    input slv_state_e    state_q,
    input logic          busy,
    input logic          start_det,
    input logic          stop_det,
    input logic [AW-1:0] addr_q
);
    assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_oe_o);

    assert_start_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_DEV));

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (((state_q == ST_WDAT_ACK) && ($past(state_q) == ST_WDAT)) ||
         ((state_q == ST_RACK) && ($past(state_q) == ST_RDAT)))
        |-> (addr_q == AW'($past(addr_q) + 1'b1)));

    assert_ack_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEV_ACK) |-> !busy);

    assert_sda_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    assert_hold_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !sda_oe_o);

    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE));

endmodule

bind twi_mem_slave twi_mem_slave_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe_o  (sda_oe_o),
    .state_q   (state_q),
    .busy      (busy),
    .start_det (start_det),
    .stop_det  (stop_det),
    .addr_q    (addr_q)
);

// File: tb/twi_mem_slave_bench.sv
module twi_mem_slave_bench;
    localparam int Q  = 10;
    localparam int WR = 1500;
    localparam logic [7:0] DEV_W = 8'hA0;
    localparam logic [7:0] DEV_R = 8'hA1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic sda_bus;

    assign sda_bus = ~(m_low | sda_oe);

    always #4 clk = ~clk;

    twi_mem_slave #(
        .DEV_ADDR    (7'h50),
        .MEM_BYTES   (2048),
        .WR_CYCLES   (WR),
        .SYNC_STAGES (2)
    ) u_twi_mem_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe)
    );

    int    total = 0;
    int    bad   = 0;
    int    exp_q[$];
    string tag_q[$];
    int    obs_q[$];
    logic [7:0] buf_b [8];

    task automatic expect_item(input string tag, input int v);
        tag_q.push_back(tag);
        exp_q.push_back(v);
    endtask

    task automatic observe(input int v);
        obs_q.push_back(v);
    endtask

    // Monitor: pairs observed items with expected ones
    initial begin
        forever begin
            @(posedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                int    o;
                int    e;
                string t;
                o = obs_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (o !== e) begin
                    bad++;
                    $display("FAIL %s actual=%0h expected=%0h", t, o, e);
                end
            end
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_low = 1'b1; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_low = 1'b0; wq(); wq();
    endtask

    task automatic send_bit(input logic b);
        m_low = ~b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        m_low = 1'b0; wq();
        m_scl = 1'b1; wq();
        b = sda_bus; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output int ack);
        logic bb;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(bb);
        ack = bb ? 0 : 1;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~mack);
    endtask

    task automatic send_checked(input logic [7:0] v, input string tag, input int exp_ack);
        int a;
        expect_item(tag, exp_ack);
        send_byte(v, a);
        observe(a);
    endtask

    // Write n bytes from buf_b at address a, ending with a stop
    task automatic write_block(input int a, input int n);
        bus_start();
        send_checked(DEV_W, "R3 write device ack", 1);
        send_checked(8'(a >> 8), "R4 high address ack", 1);
        send_checked(8'(a), "R4 low address ack", 1);
        for (int i = 0; i < n; i++) send_checked(buf_b[i], "R4 data ack", 1);
        bus_stop();
    endtask

    // Random read of n bytes at a, compared against buf_b
    task automatic read_block(input int a, input int n, input string tag);
        logic [7:0] v;
        bus_start();
        send_checked(DEV_W, "R6 device ack after write cycle", 1);
        send_checked(8'(a >> 8), "R4 high address ack", 1);
        send_checked(8'(a), "R4 low address ack", 1);
        bus_start();
        send_checked(DEV_R, "R2 repeated start read device ack", 1);
        for (int i = 0; i < n; i++) begin
            expect_item(tag, int'(buf_b[i]));
            recv_byte(v, (i != n - 1));
            observe(int'(v));
        end
    endtask

    task automatic settle_write();
        repeat (WR + 100) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: released after reset
        expect_item("R1 sda_oe after reset", 0);
        observe(int'(sda_oe));

        // R4: plain write of three bytes
        buf_b[0] = 8'hA5; buf_b[1] = 8'h3C; buf_b[2] = 8'hF0;
        write_block(12'h123, 3);

        // R6: poll at once, write cycle running -> no ack
        bus_start();
        send_checked(DEV_W, "R6 busy device nack", 0);
        bus_stop();

        // R6/R8/R9: after the write cycle, random read with NACK on the last byte
        settle_write();
        read_block(12'h123, 3, "R8 read data msb first");
        // R9: extra pulses after the NACK see a released line
        expect_item("R9 released after nack", 8'hFF);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            recv_bit(b);
            v[i] = b;
        end
        observe(int'(v));
        bus_stop();

        // R7/R10: address-only write above did not start a write cycle
        bus_start();
        send_checked(DEV_W, "R7 R10 ack with no write cycle", 1);
        bus_stop();

        // R3: foreign device address is ignored
        bus_start();
        send_checked(8'hA2, "R3 foreign address nack", 0);
        send_checked(8'h00, "R3 silent after mismatch", 0);
        bus_stop();

        // R5: wrap from top address to zero
        buf_b[0] = 8'h11; buf_b[1] = 8'h22;
        write_block(12'h7FF, 2);
        settle_write();
        buf_b[0] = 8'h11;
        read_block(12'h7FF, 1, "R5 byte at top address");
        bus_stop();
        bus_start();
        send_checked(DEV_R, "R8 current address read ack", 1);
        expect_item("R5 wrapped byte at zero", 8'h22);
        recv_byte(v, 1'b0);
        observe(int'(v));
        bus_stop();

        // R2/R6: repeated start in the middle of a data byte
        bus_start();
        send_checked(DEV_W, "R3 write device ack", 1);
        send_checked(8'h00, "R4 high address ack", 1);
        send_checked(8'h50, "R4 low address ack", 1);
        send_checked(8'h77, "R4 data ack", 1);
        send_checked(8'h88, "R4 data ack", 1);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        send_checked(DEV_W, "R2 ack after mid-byte start", 1);
        bus_stop();
        bus_start();
        send_checked(DEV_W, "R6 busy after write with restart", 0);
        bus_stop();
        settle_write();
        buf_b[0] = 8'h77; buf_b[1] = 8'h88;
        read_block(12'h050, 2, "R2 R4 bytes kept across restart");
        bus_stop();

        expect_item("R1 released when idle", 0);
        observe(int'(sda_oe));

        repeat (4) @(posedge clk);
        if (exp_q.size() != 0 || obs_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard actual=%0d/%0d expected=0/0", exp_q.size(), obs_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule